// File: doc/BRIEF.md
# Flash Line-Buffer Fetch Accelerator

This block sits between a CPU local bus and one flash bank that delivers 128-bit lines. It keeps three line buffers, each tagged with a 15-bit line address: a prefetch buffer fed by sequential code fetches and look-ahead reads, a branch-trail buffer that holds the target line of the last non-sequential code fetch, and a data buffer. An instruction/data indicator on each request steers it to the code buffers or to the data buffer. Reads of 8, 16 and 32 bits are served from a buffer when the current acceleration level allows it. Otherwise the block issues a flash line read that lasts a programmed number of clocks, and it holds the CPU with a wait signal until the line arrives.

A two-bit level register selects off, partial or full acceleration, and a three-bit register sets the flash access time. Both are written through a small configuration port. A busy input stands for flash program or erase activity. While it is high, reads stall and all buffers are cleared.

The controller is a three-state machine. ST_IDLE has no flash access in flight. ST_FETCH is a demand line read that the CPU waits on. ST_PREF is a look-ahead read of the next line. The transitions are:
- IDLE→FETCH on a request that cannot be served from a buffer.
- IDLE→PREF when the CPU takes a line from the look-ahead holding latch.
- FETCH→PREF when the read completes with acceleration on. The look-ahead target is the next line after code, or the saved look-ahead target after data.
- FETCH→IDLE when the read completes with acceleration off, or after a data read with no saved target.
- PREF→FETCH when a request misses, which aborts the look-ahead.
- PREF→PREF when the CPU joins the look-ahead and the read completes. The next line is started.
- PREF→IDLE when the look-ahead completes unclaimed into the holding latch.
- Any state→IDLE on a level write or on busy.

Top module: `flash_line_accel`

## Requirements
- R1: After reset the level is off (00) and the access time is 7. With no request, cpu_wait and flash_rd are low, and the first read waits exactly 7 cycles.
- R2: At level off (00), every read waits the full access time, even when the line was read before. No look-ahead read is issued: flash_rd is low in the cycle after delivery.
- R3: cpu_size 00 selects a byte, 01 a halfword and 10 a word. Word index addr[3:2] selects line bits [32*i+31:32*i]. A byte is taken from lane addr[1:0] and a halfword from half addr[1]. The result is zero-extended, and the low address bits below the access size are ignored.
- R4: At level full (10), a code read that hits the prefetch or branch-trail buffer returns with no wait. In the cycle after a code line is delivered, a look-ahead read of the next line is under way (flash_rd high, flash_addr = line+1).
- R5: A completed look-ahead line is held until a code read presents its address, which is then served with no wait. A code read of another line discards it, so a later read of the discarded line pays the full access time.
- R6: A code read that matches a look-ahead read in progress waits only for the remaining time. A sequential read of the next line, issued right after a delivery with access time T, waits T-1 cycles.
- R7: At level partial (01), sequential code hits return with no wait. Non-sequential code reads and all data reads wait the full access time.
- R8: At level full, a data read hitting the data buffer returns with no wait. A data miss aborts a look-ahead in progress and waits the full time, and the look-ahead of the saved line restarts in the cycle after the data delivery.
- R9: A non-sequential code fetch fills the branch-trail buffer and a sequential miss fills the prefetch buffer, so both lines then hit with no wait.
- R10: An accepted level write clears all buffers. A write of the reserved level 11 is ignored and changes neither the level nor the buffers.
- R11: While flash_busy is high, any request is held with cpu_wait high and all buffers are cleared. After busy falls, the read takes the full access time.
- R12: A write of access time 0 is ignored. A new access time written during a flash access does not change that access and applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Read request, held until cpu_wait is low |
| cpu_addr | input | 19 | Byte address; [18:4] is the line tag |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_code | input | 1 | 1 = instruction fetch, 0 = data read |
| cpu_seq | input | 1 | 1 = sequential to the previous code fetch |
| cpu_wait | output | 1 | CPU stall |
| cpu_rdata | output | 32 | Read data, valid when cpu_req is high and cpu_wait is low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = level register, 1 = access-time register |
| cfg_wdata | input | 3 | Write value |
| flash_busy | input | 1 | Flash program/erase in progress |
| flash_rd | output | 1 | A flash line read is in progress |
| flash_addr | output | 15 | Line address of that read |
| flash_line | input | 128 | Line returned by the flash for flash_addr |

## Verification
A stale tag or a valid bit left set shows up at once as a zero-wait read returning the data of another line, or as a missing stall after a level write or a busy period. A wrong counter or state shows up as a stall count off by one or more on the very next read. A look-ahead started at the wrong time or at the wrong line is visible on flash_rd and flash_addr in the cycle after a delivery. A look-ahead that is lost or mis-routed shows up as a full-length stall where a shortened or zero stall is expected.

// File: rtl/accel_pkg.sv
package accel_pkg;
    localparam int LINE_W  = 128;
    localparam int WORD_W  = 32;
    localparam int WORDS   = LINE_W / WORD_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PREF  = 2'd2
    } fsm_t;

    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_PART = 2'b01,
        MD_FULL = 2'b10
    } level_t;

    typedef enum logic [1:0] {
        K_SEQ  = 2'd0,
        K_BR   = 2'd1,
        K_DATA = 2'd2
    } kind_t;
endpackage

// File: rtl/line_buf.sv
module line_buf #(
    parameter int TAGW = 15,
    parameter int LW   = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr,
    input  logic [TAGW-1:0] wr_tag,
    input  logic [LW-1:0]   wr_line,
    input  logic [TAGW-1:0] look_tag,
    output logic            hit,
    output logic            vld_o,
    output logic [LW-1:0]   line_o
);
    logic            vld;
    logic [TAGW-1:0] tag;
    logic [LW-1:0]   line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld <= 1'b0;
        else if (clr) vld <= 1'b0;
        else if (wr)  vld <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr && !clr) begin
            tag  <= wr_tag;
            line <= wr_line;
        end
    end

    assign hit    = vld && (tag == look_tag);
    assign vld_o  = vld;
    assign line_o = line;
endmodule

// File: rtl/word_pick.sv
module word_pick #(
    parameter int LW = 128,
    parameter int WW = 32
) (
    input  logic [LW-1:0] line,
    input  logic [1:0]    word_sel,
    input  logic [1:0]    lane,
    input  logic [1:0]    size,
    output logic [WW-1:0] data
);
    localparam int NW = LW / WW;
    logic [WW-1:0] words [NW];
    logic [WW-1:0] w;

    for (genvar i = 0; i < NW; i++) begin : g_split
        assign words[i] = line[i*WW +: WW];
    end

    always_comb begin
        w = words[word_sel];
        unique case (size)
            2'b00:   data = {{(WW-8){1'b0}},  w[lane*8 +: 8]};
            2'b01:   data = {{(WW-16){1'b0}}, w[lane[1]*16 +: 16]};
            default: data = w;
        endcase
    end
endmodule

// File: rtl/flash_line_accel.sv
module flash_line_accel
    import accel_pkg::*;
#(
    parameter int TAGW    = 15,
    parameter int TIMW    = 3,
    parameter int TIM_RST = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic [TAGW+3:0]       cpu_addr,
    input  logic [1:0]            cpu_size,
    input  logic                  cpu_code,
    input  logic                  cpu_seq,
    output logic                  cpu_wait,
    output logic [WORD_W-1:0]     cpu_rdata,
    input  logic                  cfg_wr,
    input  logic                  cfg_sel,
    input  logic [TIMW-1:0]       cfg_wdata,
    input  logic                  flash_busy,
    output logic                  flash_rd,
    output logic [TAGW-1:0]       flash_addr,
    input  logic [LINE_W-1:0]     flash_line
);
    localparam logic [TIMW-1:0] TIM_INIT = TIM_RST[TIMW-1:0];

    fsm_t            state, state_n;
    level_t          mode_q;
    kind_t           kind_q, kind_n;
    logic [TIMW-1:0] tim_q, cnt, cnt_n;
    logic [TAGW-1:0] fa_tag, fa_tag_n, pf_next, pf_next_n;
    logic            pf_next_vld, pf_next_vld_n;
    logic            fl_vld, fl_vld_n, fl_cap;
    logic [TAGW-1:0] fl_tag;
    logic [LINE_W-1:0] fl_line;

    logic [TAGW-1:0] tag;
    logic mode_wr, tim_wr, inval;
    logic hit_pf, hit_bt, hit_dt, hit_fl;
    logic pf_vld, bt_vld, dt_vld;
    logic [LINE_W-1:0] pf_line, bt_line, dt_line, src_line;
    logic allow_code, imm, imm_now, join_pf, deliver_now;
    logic wr_pf, wr_bt, wr_dt, mv_fl;

    assign tag     = cpu_addr[TAGW+3:4];
    assign mode_wr = cfg_wr && !cfg_sel && (cfg_wdata[1:0] != 2'b11);
    assign tim_wr  = cfg_wr && cfg_sel && (cfg_wdata != '0);
    assign inval   = mode_wr || flash_busy;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_OFF;
            tim_q  <= TIM_INIT;
        end else begin
            if (mode_wr) mode_q <= level_t'(cfg_wdata[1:0]);
            if (tim_wr)  tim_q  <= cfg_wdata;
        end
    end

    // line buffers
    line_buf #(.TAGW(TAGW), .LW(LINE_W)) u_pf (
        .clk(clk), .rst_n(rst_n), .clr(inval), .wr(wr_pf),
        .wr_tag(mv_fl ? fl_tag : fa_tag),
        .wr_line(mv_fl ? fl_line : flash_line),
        .look_tag(tag), .hit(hit_pf), .vld_o(pf_vld), .line_o(pf_line));

    line_buf #(.TAGW(TAGW), .LW(LINE_W)) u_bt (
        .clk(clk), .rst_n(rst_n), .clr(inval), .wr(wr_bt),
        .wr_tag(fa_tag), .wr_line(flash_line),
        .look_tag(tag), .hit(hit_bt), .vld_o(bt_vld), .line_o(bt_line));

    line_buf #(.TAGW(TAGW), .LW(LINE_W)) u_dt (
        .clk(clk), .rst_n(rst_n), .clr(inval), .wr(wr_dt),
        .wr_tag(fa_tag), .wr_line(flash_line),
        .look_tag(tag), .hit(hit_dt), .vld_o(dt_vld), .line_o(dt_line));

    // hit classification
    assign hit_fl     = fl_vld && (fl_tag == tag) && (state == ST_IDLE);
    assign allow_code = (mode_q == MD_FULL) || ((mode_q == MD_PART) && cpu_seq);
    assign imm        = cpu_req && (cpu_code ? (allow_code && (hit_pf || hit_bt || hit_fl))
                                             : ((mode_q == MD_FULL) && hit_dt));
    assign imm_now    = imm && (state != ST_FETCH) && !flash_busy;
    assign join_pf    = (state == ST_PREF) && cpu_req && cpu_code && allow_code
                        && (tag == fa_tag) && !imm;
    assign deliver_now = !flash_busy && (cnt == '0)
                        && ((state == ST_FETCH) || join_pf);

    assign cpu_wait   = cpu_req && !(imm_now || deliver_now);
    assign flash_rd   = (state != ST_IDLE);
    assign flash_addr = fa_tag;

    always_comb begin
        if (deliver_now)  src_line = flash_line;
        else if (!cpu_code) src_line = dt_line;
        else if (hit_pf)  src_line = pf_line;
        else if (hit_bt)  src_line = bt_line;
        else              src_line = fl_line;
    end

    word_pick #(.LW(LINE_W), .WW(WORD_W)) u_pick (
        .line(src_line), .word_sel(cpu_addr[3:2]), .lane(cpu_addr[1:0]),
        .size(cpu_size), .data(cpu_rdata));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            fa_tag      <= '0;
            kind_q      <= K_SEQ;
            pf_next     <= '0;
            pf_next_vld <= 1'b0;
            fl_vld      <= 1'b0;
        end else begin
            state       <= state_n;
            cnt         <= cnt_n;
            fa_tag      <= fa_tag_n;
            kind_q      <= kind_n;
            pf_next     <= pf_next_n;
            pf_next_vld <= pf_next_vld_n;
            fl_vld      <= fl_vld_n;
        end
    end

    always_ff @(posedge clk) begin
        if (fl_cap) begin
            fl_tag  <= fa_tag;
            fl_line <= flash_line;
        end
    end

    // next state and control
    always_comb begin
        state_n       = state;
        cnt_n         = cnt;
        fa_tag_n      = fa_tag;
        kind_n        = kind_q;
        pf_next_n     = pf_next;
        pf_next_vld_n = pf_next_vld;
        fl_vld_n      = fl_vld;
        fl_cap        = 1'b0;
        wr_pf         = 1'b0;
        wr_bt         = 1'b0;
        wr_dt         = 1'b0;
        mv_fl         = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req && !flash_busy) begin
                    if (!imm) begin
                        state_n  = ST_FETCH;
                        cnt_n    = tim_q - 1'b1;
                        fa_tag_n = tag;
                        kind_n   = !cpu_code ? K_DATA : (cpu_seq ? K_SEQ : K_BR);
                        if (cpu_code) fl_vld_n = 1'b0;
                    end else if (cpu_code && !hit_pf && !hit_bt && hit_fl) begin
                        mv_fl         = 1'b1;
                        wr_pf         = 1'b1;
                        fl_vld_n      = 1'b0;
                        state_n       = ST_PREF;
                        cnt_n         = tim_q - 1'b1;
                        fa_tag_n      = tag + 1'b1;
                        pf_next_n     = tag + 1'b1;
                        pf_next_vld_n = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (cnt != '0) begin
                    cnt_n = cnt - 1'b1;
                end else begin
                    wr_pf = (kind_q == K_SEQ);
                    wr_bt = (kind_q == K_BR);
                    wr_dt = (kind_q == K_DATA);
                    cnt_n = tim_q - 1'b1;
                    if (mode_q == MD_OFF) begin
                        state_n = ST_IDLE;
                    end else if (kind_q != K_DATA) begin
                        state_n       = ST_PREF;
                        fa_tag_n      = fa_tag + 1'b1;
                        pf_next_n     = fa_tag + 1'b1;
                        pf_next_vld_n = 1'b1;
                    end else if (pf_next_vld) begin
                        state_n  = ST_PREF;
                        fa_tag_n = pf_next;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_PREF: begin
                if (cpu_req && !flash_busy && !imm && !join_pf) begin
                    state_n  = ST_FETCH;
                    cnt_n    = tim_q - 1'b1;
                    fa_tag_n = tag;
                    kind_n   = !cpu_code ? K_DATA : (cpu_seq ? K_SEQ : K_BR);
                    if (cpu_code) fl_vld_n = 1'b0;
                end else if (cnt != '0) begin
                    cnt_n = cnt - 1'b1;
                end else if (join_pf) begin
                    wr_pf         = 1'b1;
                    cnt_n         = tim_q - 1'b1;
                    fa_tag_n      = fa_tag + 1'b1;
                    pf_next_n     = fa_tag + 1'b1;
                    pf_next_vld_n = 1'b1;
                end else begin
                    fl_cap   = 1'b1;
                    fl_vld_n = 1'b1;
                    state_n  = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (inval) begin
            state_n       = ST_IDLE;
            fl_vld_n      = 1'b0;
            pf_next_vld_n = 1'b0;
            fl_cap        = 1'b0;
            wr_pf         = 1'b0;
            wr_bt         = 1'b0;
            wr_dt         = 1'b0;
        end
    end

    // assertions
    a_r1_no_req_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !cpu_wait);
    a_r11_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_busy && cpu_req) |-> cpu_wait);
    a_r2_off_no_lookahead: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_OFF) |-> (state != ST_PREF));
    a_r12_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && cnt != '0 && !inval) |=>
            (state == ST_FETCH && cnt == $past(cnt) - 1'b1));
    a_r10_level_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !(pf_vld || bt_vld || dt_vld || fl_vld));
    a_r12_time_legal: assert property (@(posedge clk) disable iff (!rst_n)
        tim_q != '0);
endmodule

// File: tb/tb_flash_line_accel.sv
module tb_flash_line_accel;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic [18:0]  cpu_addr = '0;
    logic [1:0]   cpu_size = 2'b10;
    logic         cpu_code = 1'b1;
    logic         cpu_seq = 1'b1;
    logic         cpu_wait;
    logic [31:0]  cpu_rdata;
    logic         cfg_wr = 1'b0;
    logic         cfg_sel = 1'b0;
    logic [2:0]   cfg_wdata = '0;
    logic         flash_busy = 1'b0;
    logic         flash_rd;
    logic [14:0]  flash_addr;
    logic [127:0] flash_line;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] fword(input logic [14:0] ln, input logic [1:0] w);
        return {4'hC, 1'b0, ln, 10'h0, w};
    endfunction

    assign flash_line = {fword(flash_addr, 2'd3), fword(flash_addr, 2'd2),
                         fword(flash_addr, 2'd1), fword(flash_addr, 2'd0)};

    flash_line_accel dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_size(cpu_size), .cpu_code(cpu_code), .cpu_seq(cpu_seq),
        .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .flash_busy(flash_busy),
        .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_line(flash_line));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expv(input logic [14:0] ln, input logic [1:0] w,
                                         input logic [1:0] lane, input logic [1:0] sz);
        logic [31:0] x = fword(ln, w);
        if (sz == 2'b00) return {24'h0, x[lane*8 +: 8]};
        if (sz == 2'b01) return {16'h0, x[lane[1]*16 +: 16]};
        return x;
    endfunction

    task automatic cfg(input logic sel, input logic [2:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic start_read(input logic [14:0] ln, input logic [1:0] w, input logic [1:0] lane,
                              input logic [1:0] sz, input logic code, input logic seq);
        @(negedge clk);
        cpu_addr = {ln, w, lane}; cpu_size = sz; cpu_code = code; cpu_seq = seq; cpu_req = 1'b1;
    endtask

    task automatic finish_read(output logic [31:0] d, output int stalls);
        stalls = 0;
        forever begin
            #1;
            if (!cpu_wait) break;
            stalls++;
            @(negedge clk);
        end
        d = cpu_rdata;
        @(posedge clk); #1 cpu_req = 1'b0;
    endtask

    // read and check both stall count and returned value
    task automatic rd(input string req, input logic [14:0] ln, input logic [1:0] w,
                      input logic [1:0] lane, input logic [1:0] sz, input logic code,
                      input logic seq, input int exp_st);
        logic [31:0] d; int st;
        start_read(ln, w, lane, sz, code, seq);
        finish_read(d, st);
        check({req, " stalls"}, st, exp_st);
        check({req, " data"}, d, expv(ln, w, lane, sz));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_and_off;
        #1;
        check("R1 no wait at rest", cpu_wait, 0);
        check("R1 no flash read at rest", flash_rd, 0);
        rd("R1 first read full time", 15'h005, 2'd1, 2'd0, 2'b10, 1'b1, 1'b1, 7);
        check("R2 no lookahead when off", flash_rd, 0);
        rd("R2 repeat read still full time", 15'h005, 2'd2, 2'd0, 2'b10, 1'b1, 1'b1, 7);
    endtask

    task automatic t_sizes;
        rd("R3 byte lane 3", 15'h123, 2'd2, 2'd3, 2'b00, 1'b0, 1'b0, 7);
        rd("R3 upper half", 15'h123, 2'd3, 2'd3, 2'b01, 1'b0, 1'b0, 7);
        rd("R3 word ignores low bits", 15'h123, 2'd0, 2'd2, 2'b10, 1'b1, 1'b0, 7);
    endtask

    task automatic t_full_hits;
        cfg(1'b1, 3'd3);
        cfg(1'b0, 3'd2);
        rd("R4 code miss", 15'h010, 2'd0, 2'd0, 2'b10, 1'b1, 1'b1, 3);
        check("R4 lookahead active", flash_rd, 1);
        check("R4 lookahead line", flash_addr, 15'h011);
        rd("R4 prefetch buffer hit", 15'h010, 2'd1, 2'd0, 2'b10, 1'b1, 1'b1, 0);
    endtask

    task automatic t_latch;
        idle(5);
        rd("R5 held line taken", 15'h011, 2'd0, 2'd0, 2'b10, 1'b1, 1'b1, 0);
        idle(5);
        rd("R5 other line discards", 15'h040, 2'd0, 2'd0, 2'b10, 1'b1, 1'b0, 3);
        idle(5);
        rd("R5 discarded line full time", 15'h012, 2'd0, 2'd0, 2'b10, 1'b1, 1'b1, 3);
    endtask

    task automatic t_join;
        cfg(1'b1, 3'd5);
        rd("R6 miss at time 5", 15'h020, 2'd3, 2'd0, 2'b10, 1'b1, 1'b0, 5);
        rd("R6 join shortened", 15'h021, 2'd0, 2'd0, 2'b10, 1'b1, 1'b1, 4);
        cfg(1'b1, 3'd3);
    endtask

    task automatic t_partial;
        cfg(1'b0, 3'd1);
        rd("R7 seq miss", 15'h030, 2'd0, 2'd0, 2'b10, 1'b1, 1'b1, 3);
        rd("R7 seq hit", 15'h030, 2'd2, 2'd0, 2'b10, 1'b1, 1'b1, 0);
        rd("R7 non-seq to buffered line", 15'h030, 2'd1, 2'd0, 2'b10, 1'b1, 1'b0, 3);
        rd("R7 data read", 15'h050, 2'd0, 2'd0, 2'b10, 1'b0, 1'b0, 3);
        rd("R7 data read again", 15'h050, 2'd1, 2'd0, 2'b10, 1'b0, 1'b0, 3);
    endtask

    task automatic t_data;
        cfg(1'b0, 3'd2);
        rd("R8 code miss", 15'h060, 2'd0, 2'd0, 2'b10, 1'b1, 1'b1, 3);
        rd("R8 data aborts lookahead", 15'h070, 2'd0, 2'd0, 2'b10, 1'b0, 1'b0, 3);
        check("R8 lookahead restarted", flash_rd, 1);
        check("R8 restarted line", flash_addr, 15'h061);
        rd("R8 data buffer hit", 15'h070, 2'd3, 2'd1, 2'b01, 1'b0, 1'b0, 0);
        idle(5);
        rd("R8 restarted line held", 15'h061, 2'd1, 2'd0, 2'b10, 1'b1, 1'b1, 0);
    endtask

    task automatic t_branch;
        rd("R9 branch miss", 15'h080, 2'd0, 2'd0, 2'b10, 1'b1, 1'b0, 3);
        rd("R9 seq miss", 15'h090, 2'd0, 2'd0, 2'b10, 1'b1, 1'b1, 3);
        rd("R9 branch trail hit", 15'h080, 2'd2, 2'd0, 2'b10, 1'b1, 1'b0, 0);
        rd("R9 prefetch hit", 15'h090, 2'd3, 2'd0, 2'b10, 1'b1, 1'b1, 0);
    endtask

    task automatic t_level_write;
        cfg(1'b0, 3'd2);
        rd("R10 cleared by level write", 15'h080, 2'd0, 2'd0, 2'b10, 1'b1, 1'b0, 3);
        cfg(1'b0, 3'd3);
        rd("R10 reserved level ignored", 15'h080, 2'd1, 2'd0, 2'b10, 1'b1, 1'b1, 0);
    endtask

    task automatic t_busy;
        logic [31:0] d; int st; int held;
        @(negedge clk); flash_busy = 1'b1;
        start_read(15'h080, 2'd0, 2'd0, 2'b10, 1'b1, 1'b0);
        held = 0;
        for (int i = 0; i < 4; i++) begin
            #1; if (cpu_wait) held++;
            @(negedge clk);
        end
        flash_busy = 1'b0;
        check("R11 held while busy", held, 4);
        finish_read(d, st);
        check("R11 full time after busy", st, 3);
        check("R11 data after busy", d, expv(15'h080, 2'd0, 2'd0, 2'b10));
    endtask

    task automatic t_timing;
        logic [31:0] d; int st; int s0;
        cfg(1'b0, 3'd0);
        cfg(1'b1, 3'd0);
        rd("R12 zero time ignored", 15'h0A0, 2'd0, 2'd0, 2'b10, 1'b1, 1'b1, 3);
        cfg(1'b1, 3'd6);
        start_read(15'h0A1, 2'd1, 2'd0, 2'b10, 1'b0, 1'b0);
        s0 = 0;
        #1; if (cpu_wait) s0++;
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 3'd2;
        #1; if (cpu_wait) s0++;
        @(negedge clk); cfg_wr = 1'b0;
        finish_read(d, st);
        check("R12 access keeps old time", s0 + st, 6);
        check("R12 data", d, expv(15'h0A1, 2'd1, 2'd0, 2'b10));
        rd("R12 new time applies", 15'h0A2, 2'd0, 2'd0, 2'b10, 1'b0, 1'b0, 2);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_off();
        t_sizes();
        t_full_hits();
        t_latch();
        t_join();
        t_partial();
        t_data();
        t_branch();
        t_level_write();
        t_busy();
        t_timing();
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule